// File: doc/BRIEF.md
# Packet-DRAM Request Decoder with Sticky Error Flags

This block sits between an on-chip request source and the serialiser that drives a packet-style DRAM bus. Each incoming request carries a byte address, a length and a read/write bit. The block splits the address into device, row and column fields and sorts it into one of four regions: tracked memory, untracked memory, register space, or broadcast register space. It also forms the packet's transfer count. The result is held in a one-deep output stage and handed downstream.

Requests flow through valid/ready handshakes on both sides. `in_ready` is high whenever the output stage is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the presented packet is held unchanged.

A three-bit sticky error register collects three events:
- an accepted request into untracked memory;
- a negative acknowledge that the tracker did not expect;
- a response that arrived with no acknowledge at all.

A single clear strobe wipes all three flags. Read data from an unacknowledged response is forced to zero.

Top module: `mreq_decode_top`

## Requirements
- R1: For every accepted request, `out_col` = addr[10:0], `out_row` = addr[19:11] and `out_dev` = addr[25:20].
- R2: `out_region` is 0 for addresses below 0x00800000, 1 from 0x00800000 up to 0x03EFFFFF, 3 for addresses at or above 0x03F00000 with addr[19] set, and 2 for the rest of that upper space.
- R3: The length input holds bytes minus one (0..127, so at most a 128-byte burst). `out_cnt[6:3]` = len[6:3], and `out_cnt[2:0]` = (len[2:0] + addr[2:0]) mod 8, with no carry into bit 3.
- R4: `in_ready` = !out_valid || out_ready. While `out_valid` is high and `out_ready` is low, every output field holds its value. Packets leave in acceptance order.
- R5: Accepting a region-1 request sets `err_flags[2]` on the following cycle, and the packet is still emitted downstream.
- R6: A one-cycle `ev_nack` pulse sets `err_flags[1]` on the following cycle.
- R7: `rsp_valid` with `rsp_acked` low sets `err_flags[0]` on the following cycle. In that cycle `rd_data` is zero. An acknowledged response passes `rsp_data` to `rd_data`.
- R8: `err_clr` clears all three flags on the next cycle. A set event in the same cycle as `err_clr` wins for its own bit.
- R9: After reset `err_flags` is 0 and `out_valid` is 0. A set flag stays set until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request accepted this cycle when both are high |
| in_addr | input | 32 | Byte address |
| in_len_m1 | input | 7 | Transfer length in bytes minus one |
| in_write | input | 1 | 1 = write, 0 = read |
| out_valid | output | 1 | Decoded packet present |
| out_ready | input | 1 | Downstream takes the packet |
| out_dev | output | 6 | Device field |
| out_row | output | 9 | Row field |
| out_col | output | 11 | Column field |
| out_cnt | output | 7 | Transfer count field |
| out_write | output | 1 | Direction of the packet |
| out_region | output | 2 | Region code per R2 |
| rsp_valid | input | 1 | Response observed on the DRAM side |
| rsp_acked | input | 1 | Response carried an acknowledge |
| rsp_data | input | 32 | Raw response data |
| rd_data | output | 32 | Data returned to the requester |
| ev_nack | input | 1 | Unexpected negative-acknowledge pulse |
| err_clr | input | 1 | Write strobe to the error register (clears all) |
| err_flags | output | 3 | {over-range, unexpected nack, missing ack} |

## Verification
Two functions can collide in one cycle: the clear strobe and a flag-setting event. The clear can coincide with the acceptance of an untracked-memory request, and separately with an `ev_nack` pulse. The bench raises `err_clr` in the very cycle the handshake or pulse occurs. It then expects only the bit being set to survive, with the other two bits left at zero. Packet fields are judged by a scoreboard while `out_ready` is throttled, so stalls overlap new offers.

// File: rtl/mreq_pkg.sv
package mreq_pkg;
  typedef enum logic [1:0] {
    RGN_MEM   = 2'd0,
    RGN_UNTRK = 2'd1,
    RGN_REG   = 2'd2,
    RGN_BCAST = 2'd3
  } region_e;
endpackage

// File: rtl/mreq_addr_split.sv
module mreq_addr_split
  import mreq_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          COL_W     = 11,
  parameter int          ROW_W     = 9,
  parameter int          DEV_W     = 6,
  parameter int          BCAST_BIT = 19,
  parameter logic [31:0] TRACK_TOP = 32'h0080_0000,
  parameter logic [31:0] REG_BASE  = 32'h03F0_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DEV_W-1:0]  dev,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output region_e           region
);
  localparam int ROW_LSB = COL_W;
  localparam int DEV_LSB = COL_W + ROW_W;

  assign col = addr[ROW_LSB-1:0];
  assign row = addr[DEV_LSB-1:ROW_LSB];
  assign dev = addr[DEV_LSB+DEV_W-1:DEV_LSB];

  always_comb begin
    if (addr < ADDR_W'(TRACK_TOP))      region = RGN_MEM;
    else if (addr < ADDR_W'(REG_BASE)) region = RGN_UNTRK;
    else if (addr[BCAST_BIT])          region = RGN_BCAST;
    else                               region = RGN_REG;
  end
endmodule

// File: rtl/mreq_count_calc.sv
module mreq_count_calc #(
  parameter int LEN_W = 7,
  parameter int LOW_W = 3
) (
  input  logic [LEN_W-1:0] len_m1,
  input  logic [LOW_W-1:0] addr_lo,
  output logic [LEN_W-1:0] cnt
);
  logic [LOW_W-1:0] low_sum;
  // deliberately truncated: carry out of the low field is dropped
  assign low_sum = len_m1[LOW_W-1:0] + addr_lo;
  assign cnt     = {len_m1[LEN_W-1:LOW_W], low_sum};
endmodule

// File: rtl/mreq_err_flags.sv
module mreq_err_flags #(
  parameter int NFLAG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_ev,
  input  logic             clr,
  output logic [NFLAG-1:0] flags
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_ev[i])  flags[i] <= 1'b1;
      else if (clr)        flags[i] <= 1'b0;
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> flags[i]);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set_ev[i]) |=> !flags[i]);
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr) |=> flags[i]);
  end
endmodule

// File: rtl/mreq_decode_top.sv
module mreq_decode_top
  import mreq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int COL_W  = 11,
  parameter int ROW_W  = 9,
  parameter int DEV_W  = 6,
  parameter int LEN_W  = 7,
  parameter int LOW_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LEN_W-1:0]  in_len_m1,
  input  logic              in_write,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DEV_W-1:0]  out_dev,
  output logic [ROW_W-1:0]  out_row,
  output logic [COL_W-1:0]  out_col,
  output logic [LEN_W-1:0]  out_cnt,
  output logic              out_write,
  output logic [1:0]        out_region,
  input  logic              rsp_valid,
  input  logic              rsp_acked,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ev_nack,
  input  logic              err_clr,
  output logic [2:0]        err_flags
);
  localparam int PKT_W = DEV_W + ROW_W + COL_W + LEN_W + 1 + 2;

  logic [DEV_W-1:0] d_dev;
  logic [ROW_W-1:0] d_row;
  logic [COL_W-1:0] d_col;
  logic [LEN_W-1:0] d_cnt;
  region_e          d_rgn;
  logic             accept;
  logic [PKT_W-1:0] pkt_q;

  mreq_addr_split #(.ADDR_W(ADDR_W), .COL_W(COL_W), .ROW_W(ROW_W), .DEV_W(DEV_W))
    u_split (.addr(in_addr), .dev(d_dev), .row(d_row), .col(d_col), .region(d_rgn));

  mreq_count_calc #(.LEN_W(LEN_W), .LOW_W(LOW_W))
    u_cnt (.len_m1(in_len_m1), .addr_lo(in_addr[LOW_W-1:0]), .cnt(d_cnt));

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      pkt_q     <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        pkt_q     <= {d_dev, d_row, d_col, d_cnt, in_write, 2'(d_rgn)};
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign {out_dev, out_row, out_col, out_cnt, out_write, out_region} = pkt_q;

  logic [2:0] set_ev;
  assign set_ev = {accept && (d_rgn == RGN_UNTRK), ev_nack, rsp_valid && !rsp_acked};

  mreq_err_flags #(.NFLAG(3))
    u_err (.clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr(err_clr), .flags(err_flags));

  assign rd_data = (rsp_valid && rsp_acked) ? rsp_data : '0;

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(pkt_q)));
  p_over_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_addr >= ADDR_W'(32'h0080_0000) && in_addr < ADDR_W'(32'h03F0_0000))
      |=> (err_flags[2] && out_valid && out_region == 2'd1));
  p_nack_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack |=> err_flags[1]);
  p_noack_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_acked) |=> err_flags[0]);
  always_comb begin
    if (rst_n && rsp_valid && !rsp_acked)
      a_zero_data_r7: assert (rd_data == '0);
  end
endmodule

// File: tb/mreq_decode_top_bench.sv
module mreq_decode_top_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        in_valid = 0, in_write = 0, out_ready = 1;
  logic [31:0] in_addr = 0;
  logic [6:0]  in_len_m1 = 0;
  logic        rsp_valid = 0, rsp_acked = 0, ev_nack = 0, err_clr = 0;
  logic [31:0] rsp_data = 0;
  logic        in_ready, out_valid, out_write;
  logic [5:0]  out_dev;
  logic [8:0]  out_row;
  logic [10:0] out_col;
  logic [6:0]  out_cnt;
  logic [1:0]  out_region;
  logic [31:0] rd_data;
  logic [2:0]  err_flags;

  mreq_decode_top u_mreq_decode_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_len_m1(in_len_m1), .in_write(in_write),
    .out_valid(out_valid), .out_ready(out_ready), .out_dev(out_dev),
    .out_row(out_row), .out_col(out_col), .out_cnt(out_cnt),
    .out_write(out_write), .out_region(out_region), .rsp_valid(rsp_valid),
    .rsp_acked(rsp_acked), .rsp_data(rsp_data), .rd_data(rd_data),
    .ev_nack(ev_nack), .err_clr(err_clr), .err_flags(err_flags));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [35:0] exp_q[$];
  bit bp_en = 0;
  int cyc = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] model(logic [31:0] a, logic [6:0] l, logic w);
    logic [1:0] rg;
    logic [2:0] lo;
    lo = l[2:0] + a[2:0];
    if (a < 32'h0080_0000)      rg = 2'd0;
    else if (a < 32'h03F0_0000) rg = 2'd1;
    else if (a[19])             rg = 2'd3;
    else                        rg = 2'd2;
    return {a[25:20], a[19:11], a[10:0], l[6:3], lo, w, rg};
  endfunction

  // R1 R2 R3 R4: scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) chk("R4 unexpected packet", 1, 0);
      else chk("R1/R2/R3 packet", {out_dev, out_row, out_col, out_cnt, out_write, out_region},
               exp_q.pop_front());
    end
  end

  // R4 back-pressure pattern
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready = bp_en ? ((cyc % 3) != 0) : 1'b1;
  end

  task automatic send(logic [31:0] a, logic [6:0] l, logic w);
    bit acc;
    @(posedge clk); #2;
    in_valid = 1; in_addr = a; in_len_m1 = l; in_write = w;
    exp_q.push_back(model(a, l, w));
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #2;
    end while (!acc);
    in_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  task automatic clear_flags();
    @(posedge clk); #2 err_clr = 1;
    @(posedge clk); #2 err_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk("R9 reset flags", err_flags, 0);
    chk("R9 reset out_valid", out_valid, 0);

    // tracked memory, several patterns, with back-pressure (R1 R3 R4)
    bp_en = 1;
    send(32'h0000_0000, 7'd0, 0);
    send(32'h007F_FFFF, 7'd127, 1);
    send(32'h0012_3805, 7'd4, 1);   // low add 4+5 wraps to 1
    send(32'h0035_5A37, 7'd15, 0);  // 7+7 -> 6, upper 0001 kept
    for (int i = 0; i < 6; i++) send(32'h0010_0000 * i + i * 32'h801, 7'(i * 19), i[0]);
    drain();
    bp_en = 0;
    @(negedge clk);
    chk("R9 no flags from tracked traffic", err_flags, 0);

    // register and broadcast regions (R2)
    send(32'h03F0_1234, 7'd3, 1);
    send(32'h03F8_0800, 7'd3, 1);
    drain();
    @(negedge clk);
    chk("R2 register space sets no flag", err_flags, 0);

    // untracked access: flagged, still issued (R5)
    send(32'h0080_0000, 7'd7, 0);
    @(negedge clk);
    chk("R5 over-range flag", err_flags, 3'b100);
    send(32'h03EF_FFFF, 7'd1, 1);
    drain();
    chk("R5 packets still emitted", exp_q.size(), 0);

    // R6 nack
    @(posedge clk); #2 ev_nack = 1;
    @(posedge clk); #2 ev_nack = 0;
    @(negedge clk);
    chk("R6 nack flag", err_flags, 3'b110);

    // R7 acked passes data, unacked zero + flag
    @(posedge clk); #2 rsp_valid = 1; rsp_acked = 1; rsp_data = 32'hCAFE_0123;
    @(negedge clk);
    chk("R7 acked data", rd_data, 32'hCAFE_0123);
    @(posedge clk); #2 rsp_acked = 0; rsp_data = 32'hDEAD_BEEF;
    @(negedge clk);
    chk("R7 unacked data zero", rd_data, 0);
    @(posedge clk); #2 rsp_valid = 0;
    @(negedge clk);
    chk("R7 missing-ack flag", err_flags, 3'b111);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 flags sticky", err_flags, 3'b111);

    // R8 clear
    clear_flags();
    @(negedge clk);
    chk("R8 clear all", err_flags, 0);

    // R8 clear coinciding with untracked acceptance
    @(posedge clk); #2;
    in_valid = 1; in_addr = 32'h0100_0000; in_len_m1 = 7'd9; in_write = 1; err_clr = 1;
    exp_q.push_back(model(32'h0100_0000, 7'd9, 1));
    @(negedge clk);
    chk("R4 ready with empty stage", in_ready, 1);
    @(posedge clk); #2 in_valid = 0; err_clr = 0;
    @(negedge clk);
    chk("R8 set beats clear (over)", err_flags, 3'b100);

    // R8 clear coinciding with nack
    @(posedge clk); #2 err_clr = 1; ev_nack = 1;
    @(posedge clk); #2 err_clr = 0; ev_nack = 0;
    @(negedge clk);
    chk("R8 set beats clear (nack)", err_flags, 3'b010);
    drain();
    chk("R4 scoreboard empty", exp_q.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule